// File: doc/BRIEF.md
# Multi-Channel DMA Address Generator

This block keeps a parameter set for each of several DMA channels: a relative buffer index, a signed step, a transfer count and an enable bit. Software loads these through a one-cycle register write port. The port carries a channel number, a field selector and a data word.

An external arbiter presents a one-hot grant vector. A DMA cycle is a clock in which the granted channel is enabled. In a DMA cycle the block registers that channel's memory address onto the I/O address bus. The address is the fixed internal-RAM base plus the zero-extended index, in 32-bit word units. In the same cycle the block writes back index + step, counts the transfer down, and signals completion when the count runs out.

Top module: `dma_addr_gen`

## Requirements
- R1: After synchronous reset, `io_addr_vld` and every `done` bit are 0 and every channel is disabled, so a grant produces no address until software sets the enable. Index, step and count are not reset.
- R2: A DMA cycle in cycle t drives `io_addr_vld`=1 in cycle t+1, with `io_addr` = 0x080000 + zero-extended 19-bit index of the granted channel.
- R3: After each DMA cycle the channel index becomes index + step. The next transfer of that channel uses the updated value.
- R4: The step is a signed two's-complement value, so a negative step (for example 0x7FFF0 = -16) moves the index down.
- R5: The index wraps modulo 2^19: 0x7FFFE + 3 gives 0x00001, and 0x00001 - 2 gives 0x7FFFF.
- R6: Every DMA cycle decrements the channel count. A DMA cycle that takes the count from 1 to 0 raises that channel's `done` bit for exactly one cycle, aligned with the address, and clears the channel enable.
- R7: A write to a channel's index in the same cycle as a DMA cycle on that channel wins over the post-modify. The transfer in that cycle still uses the old index.
- R8: In a cycle with no grant, or with a grant to a disabled channel, no address is driven and no parameter of the channel changes.
- R9: Each channel's index, step and count advance only on that channel's own DMA cycles.
- R10: The write port field encoding is `wr_sel` 0 = index, 1 = step, 2 = count (low 16 bits of `wr_data`), 3 = control. For control, `wr_data` bit 0 is the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 2 | Field selector (R10) |
| wr_data | input | 19 | Write data |
| gnt | input | 4 | One-hot channel grant from the arbiter |
| io_addr_vld | output | 1 | Registered address valid |
| io_addr | output | 24 | Registered I/O address bus |
| done | output | 4 | One-cycle completion pulse per channel |

## Verification
Several rules are checked by assertions on every cycle. The grant is one-hot, and the address stays inside the 2^19-word window above the base. The bus stays quiet after any cycle with no DMA cycle. Every write-back without a same-cycle index write equals the old index plus the step. Each completion pulse lasts one cycle and follows a transfer made at count 1. Some results need planned stimulus from the bench scenarios to appear: exact address sequences for positive and negative steps, wrap in both directions, the index-write priority, the disable after completion, and the state kept across idle and disabled grants.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_STEP   = 2'd1,
    FLD_COUNT  = 2'd2,
    FLD_CTRL   = 2'd3
  } fld_e;
endpackage

// File: rtl/dmaag_chan.sv
module dmaag_chan
  import dmaag_pkg::*;
#(
  parameter int IDX_W = 19,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_data,
  input  logic             gnt,
  output logic [IDX_W-1:0] idx,
  output logic             fire,
  output logic             done
);
  logic [IDX_W-1:0] step;
  logic [CNT_W-1:0] cnt;
  logic             en;
  logic             idx_wr, step_wr, cnt_wr, ctl_wr, last;

  assign idx_wr  = wr_hit && (wr_sel == FLD_INDEX);
  assign step_wr = wr_hit && (wr_sel == FLD_STEP);
  assign cnt_wr  = wr_hit && (wr_sel == FLD_COUNT);
  assign ctl_wr  = wr_hit && (wr_sel == FLD_CTRL);
  assign fire    = gnt && en;
  assign last    = (cnt == CNT_W'(1));

  // parameter storage: no reset
  always_ff @(posedge clk) begin
    if (idx_wr)       idx <= wr_data;
    else if (fire)    idx <= idx + step;
    if (step_wr)      step <= wr_data;
    if (cnt_wr)       cnt <= wr_data[CNT_W-1:0];
    else if (fire)    cnt <= cnt - CNT_W'(1);
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fire && last;
      if (ctl_wr)            en <= wr_data[0];
      else if (fire && last) en <= 1'b0;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_postmod_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(fire) && !$past(idx_wr) |-> idx == $past(idx) + $past(step));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
    armed && done |-> $past(fire) && ($past(cnt) == CNT_W'(1)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(fire) && !$past(idx_wr) |-> $stable(idx));
endmodule

// File: rtl/dmaag_addr_out.sv
module dmaag_addr_out #(
  parameter int          NUM_CH = 4,
  parameter int          IDX_W  = 19,
  parameter int          ADDR_W = 24,
  parameter logic [31:0] BASE   = 32'h0008_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            fire,
  input  logic [NUM_CH-1:0][IDX_W-1:0] idx_all,
  output logic                         io_addr_vld,
  output logic [ADDR_W-1:0]            io_addr
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(BASE) + ADDR_W'(64'd1 << IDX_W);

  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    sel_idx = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (fire[c]) sel_idx = sel_idx | idx_all[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_addr_vld <= 1'b0;
      io_addr     <= '0;
    end else begin
      io_addr_vld <= |fire;
      if (|fire) io_addr <= BASE_A + ADDR_W'(sel_idx);
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (rst)
    io_addr_vld |-> (io_addr >= BASE_A) && (io_addr < LIMIT));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(|fire) |-> !io_addr_vld);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int          NUM_CH = 4,
  parameter int          IDX_W  = 19,
  parameter int          CNT_W  = 16,
  parameter int          ADDR_W = 24,
  parameter logic [31:0] BASE   = 32'h0008_0000,
  localparam int         CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [1:0]        wr_sel,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] gnt,
  output logic              io_addr_vld,
  output logic [ADDR_W-1:0] io_addr,
  output logic [NUM_CH-1:0] done
);
  logic [NUM_CH-1:0]            fire;
  logic [NUM_CH-1:0][IDX_W-1:0] idx_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(c));
    dmaag_chan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .wr_hit(hit), .wr_sel(wr_sel), .wr_data(wr_data),
      .gnt(gnt[c]), .idx(idx_all[c]), .fire(fire[c]), .done(done[c])
    );
  end

  dmaag_addr_out #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_out (
    .clk(clk), .rst(rst), .fire(fire), .idx_all(idx_all),
    .io_addr_vld(io_addr_vld), .io_addr(io_addr)
  );

  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_done_no_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (|done) |-> io_addr_vld);
endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [18:0] wr_data = '0;
  logic [3:0]  gnt = '0;
  logic        io_addr_vld;
  logic [23:0] io_addr;
  logic [3:0]  done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_addr_gen i_dma_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .gnt(gnt), .io_addr_vld(io_addr_vld),
    .io_addr(io_addr), .done(done)
  );

  // drive at a falling edge, return at the next one (outputs then reflect it)
  task automatic cyc(input logic [3:0] g, input logic we, input logic [1:0] ch,
                     input logic [1:0] sel, input logic [18:0] d);
    gnt = g; wr_en = we; wr_ch = ch; wr_sel = sel; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle();           cyc(4'b0, 1'b0, 2'd0, 2'd0, 19'd0); endtask
  task automatic wr(input int ch, input int sel, input logic [18:0] d);
    cyc(4'b0, 1'b1, 2'(ch), 2'(sel), d);
  endtask
  task automatic grant(input int ch); cyc(4'b1 << ch, 1'b0, 2'd0, 2'd0, 19'd0); endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_addr(input string req, input logic [23:0] exp);
    chk({req, " vld"}, 32'(io_addr_vld), 32'd1);
    chk({req, " addr"}, 32'(io_addr), 32'(exp));
  endtask

  task automatic setup(input int ch, input logic [18:0] i, input logic [18:0] s,
                       input logic [18:0] n);
    wr(ch, 0, i); wr(ch, 1, s); wr(ch, 2, n); wr(ch, 3, 19'd1);
  endtask

  task automatic t_reset();
    chk("R1 vld after reset", 32'(io_addr_vld), 0);
    chk("R1 done after reset", 32'(done), 0);
    grant(0);
    chk("R1 disabled after reset", 32'(io_addr_vld), 0);
  endtask

  task automatic t_incr();
    setup(0, 19'h00100, 19'd4, 19'd10);   // R10 field encoding
    grant(0); chk_addr("R2 first", 24'h080100);
    grant(0); chk_addr("R3 second", 24'h080104);
    grant(0); chk_addr("R3 third", 24'h080108);
    idle();
  endtask

  task automatic t_neg();
    setup(1, 19'h00040, 19'h7FFF0, 19'd100);
    grant(1); chk_addr("R4 first", 24'h080040);
    grant(1); chk_addr("R4 down", 24'h080030);
    idle();
  endtask

  task automatic t_wrap();
    setup(2, 19'h7FFFE, 19'd3, 19'd100);
    grant(2); chk_addr("R5 top", 24'h0FFFFE);
    grant(2); chk_addr("R5 wrap up", 24'h080001);
    wr(2, 0, 19'h00001); wr(2, 1, 19'h7FFFE);
    grant(2); chk_addr("R5 low", 24'h080001);
    grant(2); chk_addr("R5 wrap down", 24'h0FFFFF);
    idle();
  endtask

  task automatic t_done();
    setup(3, 19'h00000, 19'd1, 19'd2);
    grant(3); chk_addr("R6 first", 24'h080000);
    chk("R6 no done yet", 32'(done), 0);
    grant(3); chk_addr("R6 last", 24'h080001);
    chk("R6 done pulse", 32'(done), 32'h8);
    idle();
    chk("R6 done one cycle", 32'(done), 0);
    grant(3);
    chk("R6 enable cleared", 32'(io_addr_vld), 0);
    idle();
  endtask

  task automatic t_prio();
    setup(0, 19'h00200, 19'd8, 19'd50);
    cyc(4'b0001, 1'b1, 2'd0, 2'd0, 19'h00300);
    chk_addr("R7 old index used", 24'h080200);
    grant(0); chk_addr("R7 write wins", 24'h080300);
    idle();
  endtask

  task automatic t_idle();
    idle(); idle();
    chk("R8 no grant quiet", 32'(io_addr_vld), 0);
    grant(0); chk_addr("R8 ch0 unchanged", 24'h080308);
    wr(1, 3, 19'd0);
    grant(1);
    chk("R8 disabled grant quiet", 32'(io_addr_vld), 0);
    wr(1, 3, 19'd1);
    grant(1); chk_addr("R8 ch1 unchanged", 24'h080020);
    idle();
  endtask

  task automatic t_indep();
    grant(0); chk_addr("R9 ch0", 24'h080310);
    grant(1); chk_addr("R9 ch1", 24'h080010);
    grant(0); chk_addr("R9 ch0 again", 24'h080318);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_incr();
    t_neg();
    t_wrap();
    t_done();
    t_prio();
    t_idle();
    t_indep();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule